// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This controller sits beside a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Every cycle it looks at the decode, execute, memory and write-back stages. For each stage it sees a valid bit, an instruction class and the register numbers that the instruction reads or writes. From these it drives the operand-bypass selects at the execute stage and the select for store data. It also drives the hold and bubble controls that freeze or drain the front of the pipeline. The datapath, register file, ALU and memories are not part of it. They exist only as the descriptors the controller receives.

Besides the integer ALU, the pipeline has a floating-point adder. Its first execute cycle is the normal execute stage, and it spends `FP_LAT` execute cycles in total before it reaches the single memory stage. The controller keeps a small internal record of the adds in flight. It holds any instruction in the execute stage that needs an unfinished add result. It also holds a non-adder instruction that would reach the memory stage in the same cycle as an add. Register numbers are shared between integer and floating-point results.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset the floating-point tracker is empty. With no valid stage descriptor, every select and every hold or bubble output is 0.
- R2: Class codes are 0 none, 1 ALU, 2 load, 3 store, 4 FP add, 5 branch. Select codes are 0 register file, 1 memory-stage result, 2 write-back-stage result. A valid ALU or FP add writer in the memory stage whose destination equals an execute-stage source gives select 1. That source is src1 for `fwd_a`. It is src2 for `fwd_b` on non-store instructions and for `fwd_sd` on stores; `fwd_b` stays 0 for a store.
- R3: A valid ALU, load or FP add writer in the write-back stage whose destination matches gives select 2. When both the memory and write-back stages match, select 1 wins.
- R4: Register 0 and descriptors with a clear valid bit never cause a forward or a stall.
- R5: A load in the memory stage is never a bypass source (select 1 is never given for it).
- R6: A valid load in execute whose nonzero destination is read by the valid decode-stage instruction raises `hold_front` and `bubble_ex`, while `hold_ex` and `bubble_mem` stay 0. Loads read only src1; ALU, store, FP add and branch read src1 and src2. Once the load has left execute there is no stall, and the value comes from write-back with select 2.
- R7: An FP add that leaves execute stays in the adder for `FP_LAT`-1 more cycles. An execute-stage instruction that reads its nonzero destination during those cycles raises `hold_ex`, `hold_front` and `bubble_mem`. Once the add is in the memory stage the hold drops and the result is bypassed with select 1.
- R8: While an FP add is in its last execute cycle, a valid execute-stage instruction of any other class is held even without a dependence. An FP add or an empty slot in execute is not held.
- R9: An FP add held in execute enters the adder record only in the cycle in which it advances.
- R10: When an execute-stage hold and a load-use hazard coincide, `bubble_ex` is 0 and `hold_ex`, `hold_front` and `bubble_mem` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode-stage instruction present |
| id_cls | input | 3 | Decode-stage class |
| id_src1 | input | REG_W | Decode-stage first source register |
| id_src2 | input | REG_W | Decode-stage second source register |
| ex_valid | input | 1 | Execute-stage instruction present |
| ex_cls | input | 3 | Execute-stage class |
| ex_dst | input | REG_W | Execute-stage destination register |
| ex_src1 | input | REG_W | Execute-stage first source register |
| ex_src2 | input | REG_W | Execute-stage second source (store data for stores) |
| mem_valid | input | 1 | Memory-stage instruction present |
| mem_cls | input | 3 | Memory-stage class |
| mem_dst | input | REG_W | Memory-stage destination register |
| wb_valid | input | 1 | Write-back-stage instruction present |
| wb_cls | input | 3 | Write-back-stage class |
| wb_dst | input | REG_W | Write-back-stage destination register |
| fwd_a | output | 2 | Select for execute operand A |
| fwd_b | output | 2 | Select for execute operand B |
| fwd_sd | output | 2 | Select for store data |
| hold_front | output | 1 | Hold PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a bubble into the execute stage |
| hold_ex | output | 1 | Hold the execute-stage register |
| bubble_mem | output | 1 | Load a bubble into the memory stage |

## Verification
Bypass selection is tried with a writer only in memory, only in write-back, in both, and with a load in memory. These cases tell the priority order apart from a simple match, and show that a late load result is kept out of the memory-stage path. Decode-stage readers of each class are set against a load in execute, which separates the per-class source use (a load reading src2 must not stall). Timed sequences around an FP add place a dependent store, an independent ALU instruction and a second FP add at each execute cycle of the adder. These separate the dependence hold from the memory-port hold and show exactly when each one ends. A reset during an add and an add that is itself held show whether the adder record is emptied and when it is loaded.

// File: rtl/phu_pkg.sv
`timescale 1ns/1ps
package phu_pkg;
   localparam int CLS_W = 3;
   localparam int SEL_W = 2;

   typedef enum logic [CLS_W-1:0] {
      CLS_NONE   = 3'd0,
      CLS_ALU    = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_FPADD  = 3'd4,
      CLS_BRANCH = 3'd5
   } icls_e;

   typedef enum logic [SEL_W-1:0] {
      SRC_RF  = 2'd0,
      SRC_MEM = 2'd1,
      SRC_WB  = 2'd2
   } bsel_e;

   // first source read by the class
   function automatic logic reads_a(input logic [CLS_W-1:0] c);
      case (c)
         CLS_ALU, CLS_LOAD, CLS_STORE, CLS_FPADD, CLS_BRANCH: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // second source read by the class (store data for stores)
   function automatic logic reads_b(input logic [CLS_W-1:0] c);
      case (c)
         CLS_ALU, CLS_STORE, CLS_FPADD, CLS_BRANCH: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic writes_rd(input logic [CLS_W-1:0] c);
      case (c)
         CLS_ALU, CLS_LOAD, CLS_FPADD: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/phu_fwd_pick.sv
`timescale 1ns/1ps
module phu_fwd_pick
   import phu_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic                  use_op,
   input  logic [REG_W-1:0]      src,
   input  logic                  mem_valid,
   input  logic [CLS_W-1:0]      mem_cls,
   input  logic [REG_W-1:0]      mem_dst,
   input  logic                  wb_valid,
   input  logic [CLS_W-1:0]      wb_cls,
   input  logic [REG_W-1:0]      wb_dst,
   output logic [SEL_W-1:0]      sel
);
   logic live;
   logic mem_ok;
   logic wb_ok;

   // register 0 is hard-wired and never bypassed
   assign live = use_op && (src != '0);

   // a load in the memory stage has no data yet
   assign mem_ok = mem_valid && writes_rd(mem_cls) && (mem_cls != CLS_LOAD)
                   && (mem_dst == src);
   assign wb_ok  = wb_valid && writes_rd(wb_cls) && (wb_dst == src);

   always_comb begin
      sel = SRC_RF;
      if (live) begin
         if (mem_ok)     sel = SRC_MEM;
         else if (wb_ok) sel = SRC_WB;
      end
   end
endmodule

// File: rtl/phu_fp_track.sv
`timescale 1ns/1ps
module phu_fp_track #(
   parameter int REG_W = 5,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [REG_W-1:0] issue_dst,
   input  logic             chk_a,
   input  logic             chk_b,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output logic             raw_hit,
   output logic             last_busy
);
   logic [DEPTH-1:0] slot_v;
   logic [REG_W-1:0] slot_rd [DEPTH];
   logic [DEPTH-1:0] slot_hit;

   // one slot per remaining adder cycle; the adder never waits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v <= '0;
         for (int i = 0; i < DEPTH; i++) slot_rd[i] <= '0;
      end else begin
         for (int i = DEPTH - 1; i > 0; i--) begin
            slot_v[i]  <= slot_v[i-1];
            slot_rd[i] <= slot_rd[i-1];
         end
         slot_v[0]  <= issue;
         slot_rd[0] <= issue_dst;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign slot_hit[i] = slot_v[i] && (slot_rd[i] != '0) &&
                           ((chk_a && (src_a == slot_rd[i])) ||
                            (chk_b && (src_b == slot_rd[i])));
      if (i < DEPTH - 1) begin : g_march
         // R7: an add in flight moves one adder cycle per clock
         a_r7_slot_march: assert property (@(posedge clk) disable iff (!rst_n)
            slot_v[i] |=> slot_v[i+1]);
      end
   end

   assign raw_hit   = |slot_hit;
   assign last_busy = slot_v[DEPTH-1];
endmodule

// File: rtl/phu_lu_detect.sv
`timescale 1ns/1ps
module phu_lu_detect
   import phu_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             ex_valid,
   input  logic [CLS_W-1:0] ex_cls,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             id_valid,
   input  logic [CLS_W-1:0] id_cls,
   input  logic [REG_W-1:0] id_src1,
   input  logic [REG_W-1:0] id_src2,
   output logic             lu_hit
);
   logic load_live;
   logic hit_a;
   logic hit_b;

   assign load_live = ex_valid && (ex_cls == CLS_LOAD) && (ex_dst != '0);
   assign hit_a     = reads_a(id_cls) && (id_src1 == ex_dst);
   assign hit_b     = reads_b(id_cls) && (id_src2 == ex_dst);
   assign lu_hit    = load_live && id_valid && (hit_a || hit_b);
endmodule

// File: rtl/phu_stall_ctl.sv
`timescale 1ns/1ps
module phu_stall_ctl (
   input  logic ex_valid,
   input  logic ex_is_fp,
   input  logic raw_hit,
   input  logic last_busy,
   input  logic lu_hit,
   output logic ex_go,
   output logic hold_front,
   output logic bubble_ex,
   output logic hold_ex,
   output logic bubble_mem
);
   logic ex_block;
   logic port_clash;

   // older add owns the memory stage; the younger instruction yields
   assign port_clash = last_busy && !ex_is_fp;
   assign ex_block   = ex_valid && (raw_hit || port_clash);

   assign ex_go      = !ex_block;
   assign hold_ex    = ex_block;
   assign bubble_mem = ex_block;
   assign hold_front = ex_block || lu_hit;
   // a held execute register must not be overwritten by a bubble
   assign bubble_ex  = lu_hit && !ex_block;
endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit
   import phu_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int FP_LAT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  id_valid,
   input  logic [CLS_W-1:0]      id_cls,
   input  logic [REG_W-1:0]      id_src1,
   input  logic [REG_W-1:0]      id_src2,
   input  logic                  ex_valid,
   input  logic [CLS_W-1:0]      ex_cls,
   input  logic [REG_W-1:0]      ex_dst,
   input  logic [REG_W-1:0]      ex_src1,
   input  logic [REG_W-1:0]      ex_src2,
   input  logic                  mem_valid,
   input  logic [CLS_W-1:0]      mem_cls,
   input  logic [REG_W-1:0]      mem_dst,
   input  logic                  wb_valid,
   input  logic [CLS_W-1:0]      wb_cls,
   input  logic [REG_W-1:0]      wb_dst,
   output logic [SEL_W-1:0]      fwd_a,
   output logic [SEL_W-1:0]      fwd_b,
   output logic [SEL_W-1:0]      fwd_sd,
   output logic                  hold_front,
   output logic                  bubble_ex,
   output logic                  hold_ex,
   output logic                  bubble_mem
);
   localparam int TRK_DEPTH = FP_LAT - 1;
   localparam int NUM_OPS   = 3;

   if (FP_LAT < 2) begin : g_bad_lat
      $error("pipe_hazard_unit: FP_LAT must be 2 or more");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("pipe_hazard_unit: REG_W must be 1 or more");
   end

   logic ex_is_fp;
   logic ex_is_st;
   logic ex_go;
   logic fp_issue;
   logic raw_hit;
   logic last_busy;
   logic lu_hit;

   assign ex_is_fp = ex_cls == CLS_FPADD;
   assign ex_is_st = ex_cls == CLS_STORE;
   assign fp_issue = ex_valid && ex_is_fp && ex_go;

   // ---- bypass selects: operand A, operand B, store data ----
   logic [NUM_OPS-1:0] op_use;
   logic [REG_W-1:0]   op_src [NUM_OPS];
   logic [SEL_W-1:0]   op_sel [NUM_OPS];

   assign op_use[0] = ex_valid && reads_a(ex_cls);
   assign op_use[1] = ex_valid && reads_b(ex_cls) && !ex_is_st;
   assign op_use[2] = ex_valid && ex_is_st;
   assign op_src[0] = ex_src1;
   assign op_src[1] = ex_src2;
   assign op_src[2] = ex_src2;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_fwd
      phu_fwd_pick #(.REG_W(REG_W)) u_pick (
         .use_op    (op_use[g]),
         .src       (op_src[g]),
         .mem_valid (mem_valid),
         .mem_cls   (mem_cls),
         .mem_dst   (mem_dst),
         .wb_valid  (wb_valid),
         .wb_cls    (wb_cls),
         .wb_dst    (wb_dst),
         .sel       (op_sel[g])
      );
   end

   assign fwd_a  = op_sel[0];
   assign fwd_b  = op_sel[1];
   assign fwd_sd = op_sel[2];

   // ---- floating-point adder record ----
   phu_fp_track #(.REG_W(REG_W), .DEPTH(TRK_DEPTH)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (fp_issue),
      .issue_dst (ex_dst),
      .chk_a     (ex_valid && reads_a(ex_cls)),
      .chk_b     (ex_valid && reads_b(ex_cls)),
      .src_a     (ex_src1),
      .src_b     (ex_src2),
      .raw_hit   (raw_hit),
      .last_busy (last_busy)
   );

   // ---- load-use detection ----
   phu_lu_detect #(.REG_W(REG_W)) u_lu (
      .ex_valid (ex_valid),
      .ex_cls   (ex_cls),
      .ex_dst   (ex_dst),
      .id_valid (id_valid),
      .id_cls   (id_cls),
      .id_src1  (id_src1),
      .id_src2  (id_src2),
      .lu_hit   (lu_hit)
   );

   // ---- hold and bubble decisions ----
   phu_stall_ctl u_stall (
      .ex_valid   (ex_valid),
      .ex_is_fp   (ex_is_fp),
      .raw_hit    (raw_hit),
      .last_busy  (last_busy),
      .lu_hit     (lu_hit),
      .ex_go      (ex_go),
      .hold_front (hold_front),
      .bubble_ex  (bubble_ex),
      .hold_ex    (hold_ex),
      .bubble_mem (bubble_mem)
   );

   // R8: an add leaving the adder never shares the memory stage
   a_r8_single_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (last_busy && ex_valid && !ex_is_fp) |-> (hold_ex && bubble_mem));

   // R7: a reader of the add issued last cycle is held in execute
   a_r7_dep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fp_issue) && ($past(ex_dst) != '0) && ex_valid
       && reads_a(ex_cls) && (ex_src1 == $past(ex_dst))) |-> (hold_ex && hold_front));

   // R5: no bypass from a load still in the memory stage
   a_r5_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && (mem_cls == CLS_LOAD) && !(wb_valid && writes_rd(wb_cls)))
      |-> (fwd_a != SRC_MEM && fwd_b != SRC_MEM && fwd_sd != SRC_MEM));

   // R4: register 0 is never a bypass target
   a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != SRC_RF) |-> (ex_src1 != '0));
endmodule

// File: tb/pipe_hazard_unit_test.sv
`timescale 1ns/1ps
module pipe_hazard_unit_test;
   localparam int RW = 5;

   typedef struct packed {
      logic       id_v;  logic [2:0] id_c;  logic [RW-1:0] id_s1; logic [RW-1:0] id_s2;
      logic       ex_v;  logic [2:0] ex_c;  logic [RW-1:0] ex_d;  logic [RW-1:0] ex_s1; logic [RW-1:0] ex_s2;
      logic       mem_v; logic [2:0] mem_c; logic [RW-1:0] mem_d;
      logic       wb_v;  logic [2:0] wb_c;  logic [RW-1:0] wb_d;
      logic [1:0] fa;    logic [1:0] fb;    logic [1:0] fsd;
      logic       hf;    logic bex;         logic hex;  logic bm;
      logic [3:0] tag;
   } vec_t;

   // class: 0 none 1 alu 2 load 3 store 4 fpadd 5 branch; select: 0 rf 1 mem 2 wb
   localparam int NVEC = 17;
   localparam vec_t VEC [NVEC] = '{
      '{0,0,0,0, 1,1,3,1,2,    1,1,1, 0,0,0, 1,0,0, 0,0,0,0, 2},  // R2 operand A from mem
      '{0,0,0,0, 1,3,0,29,4,   1,1,4, 0,0,0, 0,0,1, 0,0,0,0, 2},  // R2 store data from mem
      '{0,0,0,0, 1,1,10,6,7,   0,0,0, 1,2,7, 0,2,0, 0,0,0,0, 3},  // R3 load result from wb
      '{0,0,0,0, 1,1,10,6,7,   1,1,6, 1,1,6, 1,0,0, 0,0,0,0, 3},  // R3 mem beats wb
      '{0,0,0,0, 1,1,10,0,0,   1,1,0, 1,1,0, 0,0,0, 0,0,0,0, 4},  // R4 register 0
      '{0,0,0,0, 1,1,10,5,3,   0,1,5, 0,1,3, 0,0,0, 0,0,0,0, 4},  // R4 invalid writers
      '{0,0,0,0, 1,1,10,9,11,  1,2,9, 1,1,9, 2,0,0, 0,0,0,0, 5},  // R5 load in mem skipped
      '{1,1,5,6, 1,2,5,29,0,   0,0,0, 0,0,0, 0,0,0, 1,1,0,0, 6},  // R6 alu reads load dst
      '{1,3,3,5, 1,2,5,29,0,   0,0,0, 0,0,0, 0,0,0, 1,1,0,0, 6},  // R6 store data reads load dst
      '{1,1,0,0, 1,2,0,29,0,   0,0,0, 0,0,0, 0,0,0, 0,0,0,0, 4},  // R4 load to r0
      '{1,2,7,5, 1,2,5,29,0,   0,0,0, 0,0,0, 0,0,0, 0,0,0,0, 6},  // R6 load ignores src2
      '{0,1,5,5, 1,2,5,29,0,   0,0,0, 0,0,0, 0,0,0, 0,0,0,0, 4},  // R4 invalid decode slot
      '{1,0,1,2, 1,5,0,1,2,    1,1,2, 0,0,0, 0,1,0, 0,0,0,0, 2},  // R2 branch operand B
      '{0,0,0,0, 1,3,0,8,8,    1,3,8, 1,2,8, 2,0,2, 0,0,0,0, 3},  // R3 store in mem writes nothing
      '{1,1,5,6, 0,0,0,0,0,    1,2,5, 0,0,0, 0,0,0, 0,0,0,0, 6},  // R6 stall over once load left
      '{0,0,0,0, 1,1,12,5,6,   0,0,0, 1,2,5, 2,0,0, 0,0,0,0, 6},  // R6 load value from wb
      '{1,4,5,1, 1,2,5,29,0,   0,0,0, 0,0,0, 0,0,0, 1,1,0,0, 6}   // R6 fp add reads load dst
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   vec_t cur = '0;
   logic [1:0] fwd_a, fwd_b, fwd_sd;
   logic hold_front, bubble_ex, hold_ex, bubble_mem;
   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pipe_hazard_unit #(.REG_W(RW), .FP_LAT(4)) uut (
      .clk(clk), .rst_n(rst_n),
      .id_valid(cur.id_v), .id_cls(cur.id_c), .id_src1(cur.id_s1), .id_src2(cur.id_s2),
      .ex_valid(cur.ex_v), .ex_cls(cur.ex_c), .ex_dst(cur.ex_d),
      .ex_src1(cur.ex_s1), .ex_src2(cur.ex_s2),
      .mem_valid(cur.mem_v), .mem_cls(cur.mem_c), .mem_dst(cur.mem_d),
      .wb_valid(cur.wb_v), .wb_cls(cur.wb_c), .wb_dst(cur.wb_d),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd),
      .hold_front(hold_front), .bubble_ex(bubble_ex), .hold_ex(hold_ex), .bubble_mem(bubble_mem)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_stall(input string req, input int hf, input int bex, input int hex, input int bm);
      chk(req, "hold_front", int'(hold_front), hf);
      chk(req, "bubble_ex",  int'(bubble_ex),  bex);
      chk(req, "hold_ex",    int'(hold_ex),    hex);
      chk(req, "bubble_mem", int'(bubble_mem), bm);
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic set_ex(input int v, input int c, input int d, input int s1, input int s2);
      cur.ex_v = 1'(v); cur.ex_c = 3'(c); cur.ex_d = RW'(d); cur.ex_s1 = RW'(s1); cur.ex_s2 = RW'(s2);
   endtask

   task automatic set_id(input int v, input int c, input int s1, input int s2);
      cur.id_v = 1'(v); cur.id_c = 3'(c); cur.id_s1 = RW'(s1); cur.id_s2 = RW'(s2);
   endtask

   task automatic set_mem(input int v, input int c, input int d);
      cur.mem_v = 1'(v); cur.mem_c = 3'(c); cur.mem_d = RW'(d);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL all-requirements watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state, nothing valid
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R1", "fwd_a", int'(fwd_a), 0);
      chk("R1", "fwd_b", int'(fwd_b), 0);
      chk("R1", "fwd_sd", int'(fwd_sd), 0);
      chk_stall("R1", 0, 0, 0, 0);
      cyc();

      // table walk with the adder record empty
      for (int k = 0; k < NVEC; k++) begin
         string t;
         cur = VEC[k];
         t = $sformatf("R%0d", VEC[k].tag);
         #1;
         chk(t, $sformatf("v%0d fwd_a", k), int'(fwd_a), int'(VEC[k].fa));
         chk(t, $sformatf("v%0d fwd_b", k), int'(fwd_b), int'(VEC[k].fb));
         chk(t, $sformatf("v%0d fwd_sd", k), int'(fwd_sd), int'(VEC[k].fsd));
         chk(t, $sformatf("v%0d hold_front", k), int'(hold_front), int'(VEC[k].hf));
         chk(t, $sformatf("v%0d bubble_ex", k), int'(bubble_ex), int'(VEC[k].bex));
         chk(t, $sformatf("v%0d hold_ex", k), int'(hold_ex), int'(VEC[k].hex));
         chk(t, $sformatf("v%0d bubble_mem", k), int'(bubble_mem), int'(VEC[k].bm));
         cyc();
      end

      // R7: store depending on an FP add
      cur = '0;
      set_ex(1, 4, 2, 3, 4); set_id(1, 3, 29, 2);
      #1 chk_stall("R7", 0, 0, 0, 0);
      cyc();
      set_ex(1, 3, 0, 29, 2); set_id(1, 1, 7, 8);
      for (int c = 0; c < 3; c++) begin
         #1 chk_stall("R7", 1, 0, 1, 1);
         cyc();
      end
      set_mem(1, 4, 2);
      #1 chk_stall("R7", 0, 0, 0, 0);
      chk("R7", "fwd_sd after add", int'(fwd_sd), 1);
      chk("R7", "fwd_a after add", int'(fwd_a), 0);
      cyc();

      // R8: independent ALU instruction meets the add at the memory port
      cur = '0;
      set_ex(1, 4, 3, 1, 1);
      cyc();
      set_ex(1, 1, 6, 4, 5);
      #1 chk_stall("R8", 0, 0, 0, 0);
      cyc();
      #1 chk_stall("R8", 0, 0, 0, 0);
      cyc();
      #1 chk_stall("R8", 1, 0, 1, 1);
      cyc();
      #1 chk_stall("R8", 0, 0, 0, 0);
      cyc();

      // R8: an FP add or an empty slot in execute is not held
      cur = '0;
      set_ex(1, 4, 3, 1, 1);
      cyc();
      set_ex(0, 1, 6, 4, 5);
      cyc();
      cyc();
      #1 chk_stall("R8 empty", 0, 0, 0, 0);
      set_ex(1, 4, 7, 4, 5);
      #1 chk_stall("R8 fp", 0, 0, 0, 0);
      cyc();
      cur = '0;
      repeat (3) cyc();

      // R9: an FP add held in execute enters the record only when it advances
      set_ex(1, 4, 2, 1, 1);
      cyc();
      set_ex(1, 4, 10, 2, 9);
      for (int c = 0; c < 3; c++) begin
         #1 chk_stall("R9 held add", 1, 0, 1, 1);
         cyc();
      end
      set_mem(1, 4, 2);
      #1 chk_stall("R9 add goes", 0, 0, 0, 0);
      chk("R9", "fwd_a", int'(fwd_a), 1);
      cyc();
      cur = '0;
      set_ex(1, 1, 6, 4, 5);
      #1 chk_stall("R9 no stale entry", 0, 0, 0, 0);
      cyc();
      set_ex(1, 1, 6, 10, 5);
      #1 chk_stall("R9 real entry", 1, 0, 1, 1);
      cyc();
      cur = '0;
      repeat (3) cyc();

      // R10: load-use and execute hold together
      set_ex(1, 4, 3, 1, 1);
      cyc();
      set_ex(0, 0, 0, 0, 0);
      cyc();
      cyc();
      set_ex(1, 2, 8, 29, 0); set_id(1, 1, 8, 1);
      #1 chk_stall("R10", 1, 0, 1, 1);
      cyc();
      #1 chk_stall("R6 load-use alone", 1, 1, 0, 0);
      cyc();

      // R1: reset empties the adder record
      cur = '0;
      set_ex(1, 4, 2, 1, 1);
      cyc();
      rst_n = 1'b0;
      cur = '0;
      cyc();
      cyc();
      rst_n = 1'b1;
      set_ex(1, 1, 6, 2, 2);
      for (int c = 0; c < 3; c++) begin
         #1 chk_stall("R1 record cleared", 0, 0, 0, 0);
         cyc();
      end

      summary();
      $finish;
   end
endmodule